// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Compare Flags

This block is a register-mapped timer for system timekeeping. A counter of parameterised width (32 bits by default) counts up on ticks from a programmable divider. The divider is fed by one of several clock-enable inputs. Software picks the input through a source field in the control word. Up to a few compare channels watch the counter. When the counter steps onto a channel's compare value, that channel's flag in the status word is set and stays set. The counter then keeps running and is never reloaded. Each flag can be routed to a single level interrupt through a matching enable bit.

Software reaches the block over a simple single-cycle 32-bit register bus. A write takes effect on the clock edge where select and write are both high. Read data is a combinational decode of the address. A software reset clears the block's state over a fixed number of cycles. Its busy bit reads back as 1 for that whole time. The reset keeps only the source field and the mode-run enables.

Top module: `tick_timer`

## Requirements
- R1: After the reset input is released, every register reads 0 and `irq` is low.
- R2: The divider value v (offset 0x04) makes the counter advance once per v+1 ticks of the selected source while the timer is enabled. A value of 0 advances it on every source tick.
- R3: The counter advances only while control bit 0 (enable) is 1. While the enable bit is 0, the divider phase is held at zero.
- R4: In all modes the counter runs through compare matches without reloading. It wraps from all-ones to 0.
- R5: Compare channel i sits at offset 0x10+4i. Its flag is status bit i (offset 0x08). The flag is set on the tick where the counter moves to a value equal to that channel's compare value, and it stays set.
- R6: Writing the status word clears each flag whose written bit is 1. Flags whose written bit is 0 are left unchanged.
- R7: If a match and a clear of the same flag fall on the same edge, the flag ends up set.
- R8: `irq` is high exactly when some status bit i and its enable bit i at offset 0x0C are both 1. It stays high until that condition ends.
- R9: Control bits [3:1] pick the tick source: 0 none, 1 `ce_periph`, 2 `ce_periph_hi`, 3 `ce_ext`, 4 `ce_slow`, 5 `ce_fast`, 6 and 7 none. Code 5 counts only while control bit 8 (fast-source enable) is also 1.
- R10: Writing 1 to control bit 15 starts a software reset. Bit 15 reads 1 for SWR_CYCLES cycles after that write and then reads 0. Bus writes made while bit 15 is 1 have no effect, and the counter holds during that time.
- R11: When the software reset ends, all state is 0 except control bits [3:1] (source) and [7:5] (mode-run enables), which keep their values.
- R12: Control bit 4 (free-run) is stored and read back. The counter at offset 0x24 is read-only. Offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ce_periph | input | 1 | Peripheral clock enable |
| ce_periph_hi | input | 1 | Fast peripheral clock enable |
| ce_ext | input | 1 | External clock enable |
| ce_slow | input | 1 | 32 kHz clock enable |
| ce_fast | input | 1 | 24 MHz clock enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit divider, three compare channels and a three-cycle software reset. The narrow counter lets a run of a few hundred cycles cross the wrap. The small divider lets every divide ratio from 1 to 4 be swept against several run lengths. The bench computes each expected count as the number of enabled edges divided by the ratio. It also walks every source code, driving a one-hot pattern and its complement on the clock-enable inputs.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DIV  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_CMP  = 8'h10;
    localparam logic [7:0] OFS_CNT  = 8'h24;

    localparam int B_EN    = 0;
    localparam int B_SRC   = 1;
    localparam int B_FRUN  = 4;
    localparam int B_MODES = 5;
    localparam int B_FAST  = 8;
    localparam int B_SWR   = 15;

    typedef enum logic [2:0] {
        SRC_OFF     = 3'd0,
        SRC_PERIPH  = 3'd1,
        SRC_PERI_HI = 3'd2,
        SRC_EXT     = 3'd3,
        SRC_SLOW    = 3'd4,
        SRC_FAST    = 3'd5
    } src_e;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_tick,
    input  logic [PSC_W-1:0] ratio_m1,
    output logic             tick
);
    logic [PSC_W-1:0] phase_d, phase_q;

    always_comb begin
        tick    = run && src_tick && (phase_q >= ratio_m1);
        phase_d = phase_q;
        if (!run)          phase_d = '0;
        else if (tick)     phase_d = '0;
        else if (src_tick) phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/tmr_cmp_flag.sv
module tmr_cmp_flag #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             clr,
    input  logic             wipe,
    output logic             flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wipe)                               flag_d = 1'b0;
        else if (tick && (cnt_next == cmp_val)) flag_d = 1'b1;
        else if (clr)                           flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PSC_W      = 12,
    parameter int NCH        = 3,
    parameter int SWR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ce_periph,
    input  logic        ce_periph_hi,
    input  logic        ce_ext,
    input  logic        ce_slow,
    input  logic        ce_fast,
    output logic        irq
);
    localparam int RW = $clog2(SWR_CYCLES + 1);

    typedef struct packed {
        logic                       en;
        logic [2:0]                 src;
        logic                       frun;
        logic [2:0]                 modes;
        logic                       fast_en;
        logic [PSC_W-1:0]           psc;
        logic [NCH-1:0]             ie;
        logic [NCH-1:0][CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]           cnt;
        logic [RW-1:0]              rst_cnt;
    } st_t;

    st_t st_d, st_q;

    logic             busy, wen, wipe, src_tick, tick;
    logic [CNT_W-1:0] cnt_next;
    logic [NCH-1:0]   flags, clr;

    always_comb begin
        busy     = (st_q.rst_cnt != '0);
        wipe     = (st_q.rst_cnt == RW'(1));
        wen      = bus_sel && bus_wr && !busy;
        cnt_next = st_q.cnt + 1'b1;
        unique case (src_e'(st_q.src))
            SRC_PERIPH:  src_tick = ce_periph;
            SRC_PERI_HI: src_tick = ce_periph_hi;
            SRC_EXT:     src_tick = ce_ext;
            SRC_SLOW:    src_tick = ce_slow;
            SRC_FAST:    src_tick = ce_fast && st_q.fast_en;
            default:     src_tick = 1'b0;
        endcase
        clr = (wen && bus_addr == OFS_STAT) ? bus_wdata[NCH-1:0] : '0;
    end

    tmr_divider #(.PSC_W(PSC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.en && !busy),
        .src_tick (src_tick),
        .ratio_m1 (st_q.psc),
        .tick     (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_cmp_flag #(.CNT_W(CNT_W)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .cnt_next (cnt_next),
            .cmp_val  (st_q.cmp[g]),
            .clr      (clr[g]),
            .wipe     (wipe),
            .flag     (flags[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = cnt_next;
        if (wen) begin
            if (bus_addr == OFS_CTRL) begin
                st_d.en      = bus_wdata[B_EN];
                st_d.src     = bus_wdata[B_SRC +: 3];
                st_d.frun    = bus_wdata[B_FRUN];
                st_d.modes   = bus_wdata[B_MODES +: 3];
                st_d.fast_en = bus_wdata[B_FAST];
                if (bus_wdata[B_SWR]) st_d.rst_cnt = RW'(SWR_CYCLES);
            end
            if (bus_addr == OFS_DIV) st_d.psc = bus_wdata[PSC_W-1:0];
            if (bus_addr == OFS_IEN) st_d.ie  = bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == 8'(OFS_CMP + 8'(4 * i)))
                    st_d.cmp[i] = bus_wdata[CNT_W-1:0];
            end
        end
        if (wipe) begin
            st_d       = '0;
            st_d.src   = st_q.src;
            st_d.modes = st_q.modes;
        end else if (busy) begin
            st_d.rst_cnt = st_q.rst_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[B_EN]        = st_q.en;
                bus_rdata[B_SRC +: 3]  = st_q.src;
                bus_rdata[B_FRUN]      = st_q.frun;
                bus_rdata[B_MODES +: 3] = st_q.modes;
                bus_rdata[B_FAST]      = st_q.fast_en;
                bus_rdata[B_SWR]       = busy;
            end
            OFS_DIV:  bus_rdata = 32'(st_q.psc);
            OFS_STAT: bus_rdata = 32'(flags);
            OFS_IEN:  bus_rdata = 32'(st_q.ie);
            OFS_CNT:  bus_rdata = 32'(st_q.cnt);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == 8'(OFS_CMP + 8'(4 * i)))
                        bus_rdata = 32'(st_q.cmp[i]);
                end
            end
        endcase
    end

    assign irq = |(flags & st_q.ie);
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 32,
    parameter int NCH   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             en,
    input logic             busy,
    input logic [NCH-1:0]   flags,
    input logic             irq,
    input logic [CNT_W-1:0] cmp0
);
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> $stable(cnt));

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tick);

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == {CNT_W{1'b1}}) |=> cnt == '0);

    a_r5_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && CNT_W'(cnt + 1'b1) == cmp0) |=> flags[0]);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);

    a_r11_wiped: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '0 && flags == '0 && !en));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (st_q.cnt),
    .en    (st_q.en),
    .busy  (busy),
    .flags (flags),
    .irq   (irq),
    .cmp0  (st_q.cmp[0])
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    localparam int PERIOD = 10;
    localparam int CW = 8;
    localparam int SWR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  ce = 5'b11111;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(PERIOD / 2) clk = ~clk;

    tick_timer #(.CNT_W(CW), .PSC_W(4), .NCH(3), .SWR_CYCLES(SWR)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ce_periph(ce[0]), .ce_periph_hi(ce[1]), .ce_ext(ce[2]),
        .ce_slow(ce[3]), .ce_fast(ce[4]),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input int src, input bit en);
        return 32'(src << 1) | 32'(en);
    endfunction

    // enables for exactly n edges with control word c, returns counter delta
    task automatic measure(input logic [31:0] c, input int n, output int delta);
        logic [31:0] a, b;
        rd(8'h24, a);
        wr(8'h00, c | 32'h1);
        repeat (n - 1) @(posedge clk);
        wr(8'h00, c & ~32'h1);
        rd(8'h24, b);
        delta = int'((b - a) & 32'hFF);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        int d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        foreach (v[i]) ;
        for (int a = 0; a <= 8'h24; a += 4) begin
            rd(8'(a), v);
            check("R1 reset value", v, 32'h0);
        end
        check("R1 irq low", 32'(irq), 32'h0);

        // R2 divider sweep
        for (int dv = 0; dv < 4; dv++) begin
            wr(8'h04, 32'(dv));
            foreach (v[i]) ;
            for (int k = 0; k < 3; k++) begin
                int n;
                n = 7 + 3 * k;
                measure(ctl(1, 0), n, d);
                check("R2 divide ratio", 32'(d), 32'(n / (dv + 1)));
            end
        end
        wr(8'h04, 32'h0);

        // R3 no counting while disabled
        rd(8'h24, c0);
        repeat (20) @(posedge clk);
        #1;
        rd(8'h24, v);
        check("R3 disabled holds", v, c0);

        // R9 source selection
        for (int s = 1; s <= 5; s++) begin
            logic [31:0] cw;
            cw = ctl(s, 0) | 32'h100;
            ce = 5'(1 << (s - 1));
            measure(cw, 9, d);
            check("R9 selected source counts", 32'(d), 32'd9);
            ce = ~5'(1 << (s - 1));
            measure(cw, 9, d);
            check("R9 other sources ignored", 32'(d), 32'd0);
        end
        ce = 5'b11111;
        measure(ctl(5, 0), 9, d);
        check("R9 fast source needs bit 8", 32'(d), 32'd0);
        measure(ctl(0, 0), 9, d);
        check("R9 code 0 none", 32'(d), 32'd0);
        measure(ctl(6, 0), 9, d);
        check("R9 code 6 none", 32'(d), 32'd0);
        measure(ctl(7, 0), 9, d);
        check("R9 code 7 none", 32'(d), 32'd0);

        // R5 flag timing
        rd(8'h24, c0);
        wr(8'h10, (c0 + 100) & 32'hFF);
        wr(8'h18, (c0 + 101) & 32'hFF);
        wr(8'h14, (c0 + 3) & 32'hFF);
        wr(8'h08, 32'h7);
        wr(8'h00, ctl(1, 1));
        repeat (2) @(posedge clk);
        #1;
        rd(8'h08, v);
        check("R5 flag not yet set", v, 32'h0);
        @(posedge clk);
        #1;
        rd(8'h08, v);
        check("R5 flag set on match", v, 32'h2);
        wr(8'h00, ctl(1, 0));

        // R7 set wins over clear
        rd(8'h24, c0);
        wr(8'h18, (c0 + 5) & 32'hFF);
        wr(8'h08, 32'h7);
        wr(8'h00, ctl(1, 1));
        repeat (4) @(posedge clk);
        wr(8'h08, 32'h4);
        wr(8'h00, ctl(1, 0));
        rd(8'h08, v);
        check("R7 set wins", v & 32'h4, 32'h4);

        // R4 wrap, no reload at match
        wr(8'h08, 32'h7);
        rd(8'h24, c0);
        wr(8'h10, (c0 + 10) & 32'hFF);
        measure(ctl(1, 0), 300, d);
        check("R4 wraps and runs through match", 32'(d), 32'(300 % 256));
        rd(8'h08, v);
        check("R4 match flagged during run", v & 32'h1, 32'h1);

        // R8 interrupt
        wr(8'h08, 32'h6);
        wr(8'h0C, 32'h0);
        check("R8 irq masked", 32'(irq), 32'h0);
        wr(8'h0C, 32'h2);
        check("R8 irq other enable", 32'(irq), 32'h0);
        wr(8'h0C, 32'h1);
        check("R8 irq asserted", 32'(irq), 32'h1);
        repeat (5) @(posedge clk);
        #1;
        check("R8 irq level holds", 32'(irq), 32'h1);

        // R6 write-one-to-clear
        wr(8'h08, 32'h0);
        rd(8'h08, v);
        check("R6 zero write keeps", v, 32'h1);
        wr(8'h08, 32'h1);
        rd(8'h08, v);
        check("R6 one write clears", v, 32'h0);
        check("R8 irq drops on clear", 32'(irq), 32'h0);

        // R12 free-run bit, read-only counter, unmapped offset
        wr(8'h00, ctl(1, 0) | 32'h10);
        rd(8'h00, v);
        check("R12 free-run readback", v, ctl(1, 0) | 32'h10);
        rd(8'h24, c0);
        wr(8'h24, 32'hA5);
        rd(8'h24, v);
        check("R12 counter read-only", v, c0);
        rd(8'h1C, v);
        check("R12 unmapped reads 0", v, 32'h0);

        // R10 / R11 software reset
        wr(8'h04, 32'h5);
        wr(8'h0C, 32'h3);
        wr(8'h14, 32'h42);
        wr(8'h00, 32'h8000 | 32'h100 | 32'hE0 | 32'h10 | ctl(3, 1));
        wr(8'h04, 32'h9);
        rd(8'h00, v);
        check("R10 busy bit set", v & 32'h8000, 32'h8000);
        @(posedge clk);
        #1;
        rd(8'h00, v);
        check("R10 busy bit still set", v & 32'h8000, 32'h8000);
        @(posedge clk);
        #1;
        rd(8'h00, v);
        check("R11 ctrl keeps source and modes", v, 32'hE6);
        rd(8'h04, v);
        check("R11 divider cleared", v, 32'h0);
        rd(8'h0C, v);
        check("R11 enables cleared", v, 32'h0);
        rd(8'h14, v);
        check("R11 compare cleared", v, 32'h0);
        rd(8'h24, v);
        check("R11 counter cleared", v, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule